// File: doc/BRIEF.md
# Redundant Channel Consistency Checker

This block is the checking end of one redundant residue channel in a residue-number arithmetic datapath. The channel holds two values that should be the same residue modulo the channel's redundant modulus: one produced locally along the normal computation, and one rebuilt by the complete conversion out of the other base. The block subtracts the rebuilt value from the local one, reduces the difference in its accumulator stage and tests the result against zero. A zero difference means the two paths agree. Any other value means the data was corrupted somewhere upstream.

A check is launched by a one-cycle strobe. Two register stages later the block presents a one-cycle verdict, pass or fail. Every failing verdict also sets a sticky alarm, which only an explicit clear removes. The channel only receives values and never drives coefficients back into the conversion. A mode input selects the special channel whose modulus is a power of two. In that channel the reduction is a plain truncation to the arithmetic width, and the modulus input plays no part.

Top module: `red_chan_checker`

## Requirements
- R1: After a synchronous reset, res_valid, res_pass, res_fail and alarm are all 0.
- R2: In modular mode (mode_trunc = 0), a strobe computes d = res_local - res_rebuilt as an integer, adds modulus when d is negative, and reports fail when the result is non-zero and pass when it is zero. Operands at or above the modulus are not reduced beforehand.
- R3: In truncation mode (mode_trunc = 1), d is (res_local - res_rebuilt) mod 2^W. The modulus input has no effect, so the verdict is fail exactly when the two residues differ.
- R4: If chk_stb is sampled high at rising edge k, then res_valid is high for exactly the cycle after edge k+1, and exactly one of res_pass and res_fail is high with it. Whenever res_valid is low, res_pass and res_fail are low too.
- R5: alarm rises at the same edge as a fail verdict and stays high until a clear is applied.
- R6: alarm_clr sampled high at an edge drops alarm at that edge, unless a fail verdict lands at that same edge. In that case the fail wins and alarm stays high.
- R7: Strobes on consecutive cycles each produce their own verdict, one per cycle, in order.
- R8: Without a strobe, changes on res_local, res_rebuilt, modulus and mode_trunc produce no verdict and leave alarm unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_stb | input | 1 | Launches one consistency check |
| mode_trunc | input | 1 | 1 selects the power-of-two channel (truncation) |
| modulus | input | W | Redundant modulus of this channel |
| res_local | input | W | Residue computed along the channel |
| res_rebuilt | input | W | Residue obtained from the complete conversion |
| alarm_clr | input | 1 | Clears the sticky alarm |
| res_valid | output | 1 | Verdict present this cycle |
| res_pass | output | 1 | Difference reduced to zero |
| res_fail | output | 1 | Corrupted data detected |
| alarm | output | 1 | Sticky corruption alarm |

## Verification
Setting the alarm and clearing it can fall on the same edge. The bench provokes this by raising alarm_clr in the cycle where a failing verdict arrives, and expects alarm to stay high because set takes priority over clear. It then repeats the collision with a passing verdict and expects the clear to take effect. Separate directed cases show the wrap-around add in modular mode (a local value of zero against a rebuilt value equal to the modulus passes). They also show that the same operands fail in truncation mode, where the modulus is ignored.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  typedef enum logic {
    RED_MODULAR  = 1'b0,
    RED_TRUNCATE = 1'b1
  } red_mode_e;
endpackage

// File: rtl/rcc_diff_stage.sv
module rcc_diff_stage
  import rcc_pkg::*;
#(
  parameter int W = 17,
  localparam int ACC_W = W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  red_mode_e        mode,
  input  logic [W-1:0]     a_in,
  input  logic [W-1:0]     b_in,
  input  logic [W-1:0]     mod_in,
  output logic             acc_vld,
  output logic [ACC_W-1:0] acc_q
);
  logic [ACC_W-1:0] raw_diff;
  logic [ACC_W-1:0] red_diff;

  // raw difference, sign carried in the extra top bit
  assign raw_diff = {1'b0, a_in} - {1'b0, b_in};

  always_comb begin
    if (mode == RED_TRUNCATE) begin
      red_diff = {1'b0, raw_diff[W-1:0]};
    end else if (raw_diff[ACC_W-1]) begin
      red_diff = raw_diff + {1'b0, mod_in};
    end else begin
      red_diff = raw_diff;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_vld <= 1'b0;
      acc_q   <= '0;
    end else begin
      acc_vld <= stb;
      if (stb) begin
        acc_q <= red_diff;
      end
    end
  end
endmodule

// File: rtl/rcc_zero_test.sv
module rcc_zero_test #(
  parameter int ACC_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_vld,
  input  logic [ACC_W-1:0] acc_q,
  output logic             fail_evt,
  output logic             res_valid,
  output logic             res_pass,
  output logic             res_fail
);
  logic acc_nonzero;

  assign acc_nonzero = |acc_q;
  assign fail_evt    = acc_vld & acc_nonzero;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_pass  <= 1'b0;
      res_fail  <= 1'b0;
    end else begin
      res_valid <= acc_vld;
      res_pass  <= acc_vld & ~acc_nonzero;
      res_fail  <= fail_evt;
    end
  end
endmodule

// File: rtl/rcc_alarm.sv
module rcc_alarm (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr,
  output logic alarm_q
);
  // a set arriving with a clear keeps the alarm raised
  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= 1'b0;
    end else begin
      alarm_q <= (alarm_q & ~clr) | set_evt;
    end
  end
endmodule

// File: rtl/red_chan_checker.sv
module red_chan_checker
  import rcc_pkg::*;
#(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         chk_stb,
  input  logic         mode_trunc,
  input  logic [W-1:0] modulus,
  input  logic [W-1:0] res_local,
  input  logic [W-1:0] res_rebuilt,
  input  logic         alarm_clr,
  output logic         res_valid,
  output logic         res_pass,
  output logic         res_fail,
  output logic         alarm
);
  localparam int ACC_W = W + 1;

  red_mode_e        mode_sel;
  logic             acc_vld;
  logic [ACC_W-1:0] acc_q;
  logic             fail_evt;

  assign mode_sel = mode_trunc ? RED_TRUNCATE : RED_MODULAR;

  rcc_diff_stage #(.W(W)) u_diff (
    .clk     (clk),
    .rst     (rst),
    .stb     (chk_stb),
    .mode    (mode_sel),
    .a_in    (res_local),
    .b_in    (res_rebuilt),
    .mod_in  (modulus),
    .acc_vld (acc_vld),
    .acc_q   (acc_q)
  );

  rcc_zero_test #(.ACC_W(ACC_W)) u_zero (
    .clk       (clk),
    .rst       (rst),
    .acc_vld   (acc_vld),
    .acc_q     (acc_q),
    .fail_evt  (fail_evt),
    .res_valid (res_valid),
    .res_pass  (res_pass),
    .res_fail  (res_fail)
  );

  rcc_alarm u_alarm (
    .clk     (clk),
    .rst     (rst),
    .set_evt (fail_evt),
    .clr     (alarm_clr),
    .alarm_q (alarm)
  );
endmodule

// File: rtl/rcc_checker_sva.sv
module rcc_checker_sva #(
  parameter int W = 17
) (
  input logic         clk,
  input logic         rst,
  input logic         chk_stb,
  input logic         mode_trunc,
  input logic [W-1:0] res_local,
  input logic [W-1:0] res_rebuilt,
  input logic         alarm_clr,
  input logic         res_valid,
  input logic         res_pass,
  input logic         res_fail,
  input logic         alarm
);
  AST_STROBE_GIVES_VERDICT: assert property (@(posedge clk) disable iff (rst)
    chk_stb |=> ##1 res_valid); // R4

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($countones({res_pass, res_fail}) == 1)); // R4

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_pass && !res_fail)); // R4

  AST_NO_STROBE_NO_VERDICT: assert property (@(posedge clk) disable iff (rst)
    !chk_stb |=> ##1 !res_valid); // R8

  AST_EQUAL_PASSES: assert property (@(posedge clk) disable iff (rst)
    (chk_stb && (res_local == res_rebuilt)) |=> ##1 res_pass); // R2

  AST_TRUNC_DIFFER_FAILS: assert property (@(posedge clk) disable iff (rst)
    (chk_stb && mode_trunc && (res_local != res_rebuilt)) |=> ##1 res_fail); // R3

  AST_FAIL_RAISES_ALARM: assert property (@(posedge clk) disable iff (rst)
    res_fail |-> alarm); // R5

  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    (alarm && !alarm_clr) |=> alarm); // R5

  AST_ALARM_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> res_fail); // R5

  AST_CLEAR_RESULT: assert property (@(posedge clk) disable iff (rst)
    alarm_clr |=> (alarm == res_fail)); // R6
endmodule

bind red_chan_checker rcc_checker_sva #(.W(W)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .chk_stb     (chk_stb),
  .mode_trunc  (mode_trunc),
  .res_local   (res_local),
  .res_rebuilt (res_rebuilt),
  .alarm_clr   (alarm_clr),
  .res_valid   (res_valid),
  .res_pass    (res_pass),
  .res_fail    (res_fail),
  .alarm       (alarm)
);

// File: tb/red_chan_checker_bench.sv
`timescale 1ns/1ps
module red_chan_checker_bench;
  localparam int W = 17;
  localparam logic [W-1:0] MODV = 17'd131027;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         chk_stb = 1'b0;
  logic         mode_trunc = 1'b0;
  logic [W-1:0] modulus = MODV;
  logic [W-1:0] res_local = '0;
  logic [W-1:0] res_rebuilt = '0;
  logic         alarm_clr = 1'b0;
  logic         res_valid, res_pass, res_fail, alarm;

  int n_checks = 0;
  int n_fails  = 0;
  logic exp_alarm = 1'b0;

  always #4 clk = ~clk;

  red_chan_checker #(.W(W)) u_red_chan_checker (
    .clk(clk), .rst(rst), .chk_stb(chk_stb), .mode_trunc(mode_trunc),
    .modulus(modulus), .res_local(res_local), .res_rebuilt(res_rebuilt),
    .alarm_clr(alarm_clr), .res_valid(res_valid), .res_pass(res_pass),
    .res_fail(res_fail), .alarm(alarm)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic model_fail(input int a, input int b, input int m, input logic tr);
    int d;
    d = a - b;
    if (tr) return (a != b);
    if (d < 0) d = d + m;
    return (d != 0);
  endfunction

  task automatic drive(input int a, input int b, input int m, input logic tr);
    res_local   = a[W-1:0];
    res_rebuilt = b[W-1:0];
    modulus     = m[W-1:0];
    mode_trunc  = tr;
    chk_stb     = 1'b1;
  endtask

  task automatic expect_verdict(input string tag, input logic f);
    chk({tag, " valid"}, res_valid, 1);
    chk({tag, " pass"}, res_pass, !f);
    chk({tag, " fail"}, res_fail, f);
    if (f) exp_alarm = 1'b1;
    chk({tag, " alarm"}, alarm, exp_alarm);
  endtask

  task automatic one_check(input string tag, input int a, input int b, input int m, input logic tr);
    logic f;
    f = model_fail(a, b, m, tr);
    @(negedge clk); drive(a, b, m, tr);
    @(negedge clk); chk_stb = 1'b0;
    @(negedge clk); expect_verdict(tag, f);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 valid", res_valid, 0);
    chk("R1 pass", res_pass, 0);
    chk("R1 fail", res_fail, 0);
    chk("R1 alarm", alarm, 0);
    rst = 1'b0;
  endtask

  task automatic t_modular;
    one_check("R2 equal", 1234, 1234, MODV, 1'b0);
    one_check("R2 wrap zero", 0, MODV, MODV, 1'b0);
    one_check("R2 a>b", 900, 100, MODV, 1'b0);
    one_check("R2 a<b", 5, 9, MODV, 1'b0);
    one_check("R2 unreduced", MODV, 0, MODV, 1'b0);
  endtask

  task automatic t_trunc;
    one_check("R3 mod ignored", 0, 1, 1, 1'b1);
    one_check("R3 equal", 77, 77, 3, 1'b1);
    one_check("R3 no wrap", 0, 5, 5, 1'b1);
  endtask

  task automatic t_clear;
    @(negedge clk); alarm_clr = 1'b1;
    @(negedge clk); alarm_clr = 1'b0;
    exp_alarm = 1'b0;
    chk("R6 plain clear", alarm, 0);
    // fail verdict lands at the same edge as the clear
    @(negedge clk); drive(10, 20, MODV, 1'b0);
    @(negedge clk); chk_stb = 1'b0; alarm_clr = 1'b1;
    @(negedge clk); alarm_clr = 1'b0;
    chk("R6 set wins fail", res_fail, 1);
    chk("R6 set wins alarm", alarm, 1);
    chk("R5 sticky", alarm, 1);
    // pass verdict with a clear
    @(negedge clk); drive(20, 20, MODV, 1'b0);
    @(negedge clk); chk_stb = 1'b0; alarm_clr = 1'b1;
    @(negedge clk); alarm_clr = 1'b0;
    chk("R6 clear with pass", alarm, 0);
    chk("R6 pass verdict", res_pass, 1);
    exp_alarm = 1'b0;
  endtask

  task automatic t_idle;
    @(negedge clk);
    res_local = 17'd3; res_rebuilt = 17'd400; mode_trunc = 1'b1; modulus = 17'd9;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      res_local = res_local + 17'd1;
      chk("R8 no verdict", res_valid, 0);
      chk("R8 alarm held", alarm, exp_alarm);
    end
  endtask

  task automatic t_pipeline;
    @(negedge clk); drive(1, 1, MODV, 1'b0);
    @(negedge clk); drive(2, 7, MODV, 1'b0);
    @(negedge clk); drive(4, 4, MODV, 1'b1);
    expect_verdict("R7 first", 1'b0);
    @(negedge clk); chk_stb = 1'b0;
    expect_verdict("R7 second", 1'b1);
    @(negedge clk);
    expect_verdict("R7 third", 1'b0);
    @(negedge clk);
    chk("R7 drained", res_valid, 0);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_modular;
        t_trunc;
        t_clear;
        t_idle;
        t_pipeline;
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=expired expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule